// File: doc/BRIEF.md
# Teletext insertion request sequencer

This block paces an external teletext source and gates the serial bits it returns into a window on the video line. On every line whose enable bit is set for the current field, it raises a request output for a run of bit periods. The request starts at a programmable horizontal position. The run length is fixed by the selected text standard and already counts the clock run-in bits.

The source answers after a programmable latency of whole bit periods. The block delays its own request by that latency to form the insertion window. Inside the window it passes the incoming text bit to the downstream encoder with a valid flag. Outside the window the bit is held at zero and the valid flag is low.

Timing is counted in bit periods: each clock is one text bit, and `hpos` is the horizontal position in bit periods. Line selection comes from two enable masks, one per field, each with one bit per line number.

Top module: `ttx_req_seq`

## Requirements
- R1: While reset is held, and at the first sample after it, `ttx_req`, `txt_valid` and `txt_bit` are all 0.
- R2: On an enabled line, `ttx_req` is 1 in the clock after `hpos` has been sampled in the range `req_start` <= `hpos` < `req_start` + window length, and 0 in the clock after any other sample.
- R3: The window length follows `std_sel`: 0 gives 360 bits, 1 gives 296 bits and 2 gives 288 bits. The value 3 turns insertion off, so no request is made.
- R4: When `field` is 0, bit `line_num` of `line_en_f0` enables the line. When `field` is 1, bit `line_num` of `line_en_f1` enables it.
- R5: On a line whose selected enable bit is 0, `ttx_req` and `txt_valid` stay 0 for the whole line.
- R6: `txt_valid` equals `ttx_req` delayed by `lead` + 1 clocks, where `lead` ranges from 0 to 2^LEAD_W-1.
- R7: When `txt_valid` is 1, `txt_bit` holds the `ttx_in` value sampled at the same edge that set it. When `txt_valid` is 0, `txt_bit` is 0.
- R8: The first request cycle moves with `req_start`: it follows the sample of `hpos` equal to `req_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-period clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_num | input | LINE_W | Current line number within the field |
| field | input | 1 | Field flag: 0 for the first field, 1 for the second |
| hpos | input | HPOS_W | Horizontal position in bit periods |
| std_sel | input | 2 | Text standard: 0 gives 360 bits, 1 gives 296, 2 gives 288, 3 turns insertion off |
| line_en_f0 | input | 2^LINE_W | Line enable mask for field 0 |
| line_en_f1 | input | 2^LINE_W | Line enable mask for field 1 |
| req_start | input | HPOS_W | Horizontal position where the request begins |
| lead | input | LEAD_W | Source latency in bit periods |
| ttx_in | input | 1 | Serial text bit from the source |
| ttx_req | output | 1 | Request to the text source |
| txt_bit | output | 1 | Gated text bit for the encoder |
| txt_valid | output | 1 | Marks the insertion window |

## Verification
The request is due one clock after the `hpos` sample that decides it. The valid flag follows `lead` + 1 clocks after the request. The gated bit appears at the same edge as the valid flag, carrying the `ttx_in` sampled at that edge.

The bench drives its inputs on the falling edge and compares shortly after each rising edge. It keeps a ring of expected request values indexed by cycle and looks up the valid flag `lead` + 1 entries back. Every line of the sweep is compared on every cycle, across all standards, both fields, enabled and disabled lines, and three pairs of start position and latency.

// File: rtl/ttx_req_seq.sv
module ttx_req_seq #(
  parameter int LINE_W = 5,
  parameter int HPOS_W = 10,
  parameter int LEAD_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINE_W-1:0]        line_num,
  input  logic                     field,
  input  logic [HPOS_W-1:0]        hpos,
  input  logic [1:0]               std_sel,
  input  logic [(1<<LINE_W)-1:0]   line_en_f0,
  input  logic [(1<<LINE_W)-1:0]   line_en_f1,
  input  logic [HPOS_W-1:0]        req_start,
  input  logic [LEAD_W-1:0]        lead,
  input  logic                     ttx_in,
  output logic                     ttx_req,
  output logic                     txt_bit,
  output logic                     txt_valid
);
  localparam int DEPTH = 1 << LEAD_W;
  localparam int CW    = HPOS_W + 1;

  logic [CW-1:0]    win_len;
  logic [CW-1:0]    win_end;
  logic             line_on;
  logic             in_win;
  logic             ins;
  logic [DEPTH-1:0] hist;
  logic [CW-1:0]    run_cnt;

  always_comb begin
    case (std_sel)
      2'd0:    win_len = CW'(360);
      2'd1:    win_len = CW'(296);
      2'd2:    win_len = CW'(288);
      default: win_len = '0;
    endcase
  end

  assign line_on = field ? line_en_f1[line_num] : line_en_f0[line_num];
  assign win_end = {1'b0, req_start} + win_len;
  assign in_win  = line_on && (hpos >= req_start) && ({1'b0, hpos} < win_end);
  assign ins     = (lead == '0) ? ttx_req : hist[lead - 1'b1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ttx_req   <= 1'b0;
      hist      <= '0;
      txt_valid <= 1'b0;
      txt_bit   <= 1'b0;
      run_cnt   <= '0;
    end else begin
      ttx_req   <= in_win;
      hist      <= {hist[DEPTH-2:0], ttx_req};
      txt_valid <= ins;
      txt_bit   <= ins & ttx_in;
      run_cnt   <= ttx_req ? run_cnt + 1'b1 : '0;
    end
  end

  // R7: the bit is forced low outside the window
  p_bit_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !txt_valid |-> !txt_bit);

  // R3: a request run never exceeds the standard's window length
  p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ttx_req && $stable(std_sel) && $stable(req_start)) |-> (run_cnt < win_len));

  // R3: insertion off means no request
  p_off_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (std_sel == 2'd3) |=> !ttx_req);

  // R5: a disabled line raises no request
  p_disabled_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(field ? line_en_f1[line_num] : line_en_f0[line_num]) |=> !ttx_req);

  // R6: with zero latency, valid follows request by one clock
  p_zero_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((lead == '0) && $stable(lead)) |=> (txt_valid == $past(ttx_req)));
endmodule

// File: tb/ttx_req_seq_tb.sv
module ttx_req_seq_tb_top;
  localparam int LINE_W = 5;
  localparam int HPOS_W = 10;
  localparam int LEAD_W = 4;
  localparam int LINE_LEN = 1 << HPOS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LINE_W-1:0] line_num = '0;
  logic field = 1'b0;
  logic [HPOS_W-1:0] hpos = '0;
  logic [1:0] std_sel = 2'd0;
  logic [31:0] line_en_f0 = 32'h0000_0005;
  logic [31:0] line_en_f1 = 32'h0000_000A;
  logic [HPOS_W-1:0] req_start = '0;
  logic [LEAD_W-1:0] lead = '0;
  logic ttx_in = 1'b0;
  logic ttx_req, txt_bit, txt_valid;

  int vectors = 0;
  int errors = 0;
  int n = 0;
  bit ring [64];
  bit done = 0;

  always #5 clk = ~clk;

  ttx_req_seq #(.LINE_W(LINE_W), .HPOS_W(HPOS_W), .LEAD_W(LEAD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .field(field), .hpos(hpos),
    .std_sel(std_sel), .line_en_f0(line_en_f0), .line_en_f1(line_en_f1),
    .req_start(req_start), .lead(lead), .ttx_in(ttx_in),
    .ttx_req(ttx_req), .txt_bit(txt_bit), .txt_valid(txt_valid));

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: got %b expected %b", tag, n, act, exp);
    end
  endtask

  function automatic int std_len(input logic [1:0] s);
    case (s)
      2'd0: return 360;
      2'd1: return 296;
      2'd2: return 288;
      default: return 0;
    endcase
  endfunction

  task automatic step(input int h);
    bit en, req_e, val_e, tin;
    int k;
    @(negedge clk);
    hpos = HPOS_W'(h);
    tin = (((n * 7) ^ (n >> 3)) & 1) != 0;
    ttx_in = tin;
    @(posedge clk);
    #1;
    en = field ? line_en_f1[line_num] : line_en_f0[line_num];
    req_e = en && (h >= int'(req_start)) && (h < int'(req_start) + std_len(std_sel));
    ring[n % 64] = req_e;
    k = n - 1 - int'(lead);
    val_e = (k >= 0) ? ring[k % 64] : 1'b0;
    check("R2 R3 R4 R5 R8 ttx_req", ttx_req, req_e);
    check("R6 txt_valid", txt_valid, val_e);
    check("R7 txt_bit", txt_bit, val_e & tin);
    n++;
  endtask

  initial begin
    int starts [3] = '{5, 40, 120};
    int leads [3] = '{0, 3, 15};
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset ttx_req", ttx_req, 1'b0);
    check("R1 reset txt_valid", txt_valid, 1'b0);
    check("R1 reset txt_bit", txt_bit, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 3; c++) begin
      for (int f = 0; f < 2; f++) begin
        for (int s = 0; s < 4; s++) begin
          for (int l = 0; l < 4; l++) begin
            @(negedge clk);
            req_start = HPOS_W'(starts[c]);
            lead = LEAD_W'(leads[c]);
            field = f[0];
            std_sel = s[1:0];
            line_num = LINE_W'(l);
            for (int h = 0; h < LINE_LEN; h++) step(h);
          end
        end
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", n);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule